// File: doc/BRIEF.md
# Fragment Depth Test and Write-Back Unit

This block sits at the end of a fixed-function raster pipeline. It takes one fragment at a time, made of a screen position, a depth value and a colour word. It looks up the depth already stored for that pixel in a depth buffer held in external memory, then compares the two depths with one of eight selectable functions. When the fragment passes, the block writes its depth and then its colour back to memory. When it fails, the block drops the fragment and makes no write.

Both buffers are reached through a single request/acknowledge memory port, so the block works strictly serially. It does not accept a new fragment until the last memory access of the previous one has been acknowledged. Pixel offsets use a padded row pitch that is a power of two, so the row term is a shift and not a multiply. Each offset is added to a per-buffer base address. When depth testing is switched off, the block skips the read and the comparison and writes only the colour. Three counters record how many fragments were tested, how many passed, and how many cycles the unit was busy.

Top module: `zt_depth_unit`

## Requirements
- R1: After a synchronous active-low reset, `frag_ready` is 1, `mem_req` is 0, and all three counters read 0.
- R2: The depth address of a fragment is `cfg_zbase + (y << 11) + x`, and its colour address is `cfg_cbase + (y << 11) + x`. Each address is a word address with one word per pixel.
- R3: For a tested fragment, the block reads the depth address first. On a pass it then writes the new depth to the depth address, and after that writes the colour to the colour address. Each request holds its address, write enable and data stable until `mem_ack` is seen.
- R4: `cfg_func` selects how the new depth N is compared with the stored depth S, as unsigned 32-bit values. The codes are: 0 never, 1 N<S, 2 N==S, 3 N<=S, 4 N>S, 5 N!=S, 6 N>=S, 7 always.
- R5: A fragment that fails the test causes no memory write. Its stored depth and its colour word are left unchanged.
- R6: With `cfg_test_en` at 0, the block issues exactly one memory access, a colour write, and it reads and writes no depth.
- R7: `frag_ready` is 0 from the cycle after a fragment is accepted until the final acknowledge of that fragment. A fragment held valid is not taken until then.
- R8: `cnt_tested` counts fragments whose depth test was evaluated, and `cnt_passed` counts those that passed. `cnt_busy` counts cycles spent off idle: with a one-cycle memory acknowledge that is 7 cycles for a passing fragment, 3 for a failing one and 2 in bypass.
- R9: `cfg_func` and `cfg_test_en` are sampled when the fragment is accepted. The base addresses must stay stable while the unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Unit idle and able to take a fragment |
| frag_x | input | 11 | Pixel column |
| frag_y | input | 11 | Pixel row |
| frag_z | input | 32 | Fragment depth |
| frag_rgba | input | 32 | Fragment colour word |
| cfg_func | input | 3 | Compare function code (R4) |
| cfg_test_en | input | 1 | 1 = depth test, 0 = colour bypass |
| cfg_zbase | input | 32 | Depth buffer base word address |
| cfg_cbase | input | 32 | Colour buffer base word address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; carries read data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| cnt_tested | output | 32 | Fragments tested |
| cnt_passed | output | 32 | Fragments passed |
| cnt_busy | output | 32 | Busy cycles |

## Verification
The assertions check the following on every cycle:
- A pending memory request stays stable until it is acknowledged.
- No request is issued while the unit reports ready.
- An acknowledged depth write is followed at once by the colour write.
- The "never" and "always" codes and bypass lead to the right next access.
- The passed count never exceeds the tested count.

Only the bench's scenarios can show that the correct addresses are produced and that the memory contents after pass, fail and bypass are as expected. The same goes for each of the ordered compare functions at their equal and unsigned boundaries, the serial handling of back-to-back fragments, and the exact busy-cycle totals.

// File: rtl/zt_pkg.sv
// Shared types for the depth test unit.
// Assumes: compare codes are fixed by the programming model.
package zt_pkg;
    typedef enum logic [2:0] {
        CMP_NEVER    = 3'd0,
        CMP_LESS     = 3'd1,
        CMP_EQUAL    = 3'd2,
        CMP_LEQUAL   = 3'd3,
        CMP_GREATER  = 3'd4,
        CMP_NOTEQUAL = 3'd5,
        CMP_GEQUAL   = 3'd6,
        CMP_ALWAYS   = 3'd7
    } cmp_fn_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_CMP  = 3'd2,
        ST_WRZ  = 3'd3,
        ST_WRC  = 3'd4
    } seq_state_e;

    localparam int NUM_FN = 8;
endpackage

// File: rtl/zt_compare.sv
// Depth comparator: evaluates every compare function side by side and
// selects one result by code. Purely combinational.
// Assumes: depths are unsigned.
module zt_compare #(
    parameter int DW = 32
) (
    input  logic [2:0]    fn,
    input  logic [DW-1:0] new_z,
    input  logic [DW-1:0] old_z,
    output logic          pass
);
    import zt_pkg::*;

    logic lt, eq;
    logic [NUM_FN-1:0] res;

    // basic relations shared by all functions
    always_comb begin
        lt = new_z < old_z;
        eq = new_z == old_z;
    end

    // one result per compare code
    always_comb begin
        res[CMP_NEVER]    = 1'b0;
        res[CMP_LESS]     = lt;
        res[CMP_EQUAL]    = eq;
        res[CMP_LEQUAL]   = lt | eq;
        res[CMP_GREATER]  = ~(lt | eq);
        res[CMP_NOTEQUAL] = ~eq;
        res[CMP_GEQUAL]   = ~lt;
        res[CMP_ALWAYS]   = 1'b1;
    end

    // select the requested function
    always_comb pass = res[fn];
endmodule

// File: rtl/zt_addr.sv
// Pixel address generator: base + (row << pitch_log2) + column.
// Assumes: the column is below the padded pitch, so rows never overlap.
module zt_addr #(
    parameter int AW         = 32,
    parameter int XW         = 11,
    parameter int YW         = 11,
    parameter int PITCH_LOG2 = 11
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr
);
    localparam int OFFW = YW + PITCH_LOG2;

    logic [OFFW-1:0] offset;

    // shift replaces the row multiply
    always_comb begin
        offset = {y, {PITCH_LOG2{1'b0}}} | OFFW'(x);
        addr   = base + AW'(offset);
    end
endmodule

// File: rtl/zt_perf.sv
// Performance counters: tested, passed and busy cycles, one incrementer each.
// Assumes: counters wrap silently at full scale.
module zt_perf #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_tested,
    input  logic          inc_passed,
    input  logic          inc_busy,
    output logic [CW-1:0] cnt_tested,
    output logic [CW-1:0] cnt_passed,
    output logic [CW-1:0] cnt_busy
);
    localparam int NCNT = 3;

    logic [NCNT-1:0]   inc;
    logic [CW-1:0]     cnt [NCNT];

    always_comb inc = {inc_busy, inc_passed, inc_tested};

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        // count one event class
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt[i] <= '0;
            else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
        end
    end

    assign cnt_tested = cnt[0];
    assign cnt_passed = cnt[1];
    assign cnt_busy   = cnt[2];

    // passes are a subset of tests
    assert_pass_le_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_passed <= cnt_tested);
endmodule

// File: rtl/zt_depth_unit.sv
// Depth test and write-back unit. Serial sequencer over a single memory
// port: read depth, compare, write depth, write colour; bypass writes
// colour only. Assumes: base addresses are stable while busy; memory
// returns a one-cycle mem_ack per request, with read data on it.
module zt_depth_unit #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int XW         = 11,
    parameter int YW         = 11,
    parameter int PITCH_LOG2 = 11,
    parameter int CW         = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frag_valid,
    output logic          frag_ready,
    input  logic [XW-1:0] frag_x,
    input  logic [YW-1:0] frag_y,
    input  logic [DW-1:0] frag_z,
    input  logic [DW-1:0] frag_rgba,
    input  logic [2:0]    cfg_func,
    input  logic          cfg_test_en,
    input  logic [AW-1:0] cfg_zbase,
    input  logic [AW-1:0] cfg_cbase,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic [CW-1:0] cnt_tested,
    output logic [CW-1:0] cnt_passed,
    output logic [CW-1:0] cnt_busy
);
    import zt_pkg::*;

    seq_state_e    state, state_nx;
    logic [XW-1:0] f_x;
    logic [YW-1:0] f_y;
    logic [DW-1:0] f_z, f_c, old_z;
    logic [2:0]    f_fn;
    logic          f_en;
    logic          accept, pass;
    logic [AW-1:0] zaddr, caddr;

    assign frag_ready = (state == ST_IDLE);
    assign accept     = frag_valid & frag_ready;

    zt_addr #(.AW(AW), .XW(XW), .YW(YW), .PITCH_LOG2(PITCH_LOG2)) i_zaddr (
        .x(f_x), .y(f_y), .base(cfg_zbase), .addr(zaddr));

    zt_addr #(.AW(AW), .XW(XW), .YW(YW), .PITCH_LOG2(PITCH_LOG2)) i_caddr (
        .x(f_x), .y(f_y), .base(cfg_cbase), .addr(caddr));

    zt_compare #(.DW(DW)) i_cmp (
        .fn(f_fn), .new_z(f_z), .old_z(old_z), .pass(pass));

    // capture fragment and mode on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_x  <= '0;
            f_y  <= '0;
            f_z  <= '0;
            f_c  <= '0;
            f_fn <= '0;
            f_en <= 1'b0;
        end else if (accept) begin
            f_x  <= frag_x;
            f_y  <= frag_y;
            f_z  <= frag_z;
            f_c  <= frag_rgba;
            f_fn <= cfg_func;
            f_en <= cfg_test_en;
        end
    end

    // latch stored depth when the read returns
    always_ff @(posedge clk) begin
        if (!rst_n)                          old_z <= '0;
        else if (state == ST_RD && mem_ack)  old_z <= mem_rdata;
    end

    // sequencer next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)  state_nx = cfg_test_en ? ST_RD : ST_WRC;
            ST_RD:   if (mem_ack) state_nx = ST_CMP;
            ST_CMP:  state_nx = pass ? ST_WRZ : ST_IDLE;
            ST_WRZ:  if (mem_ack) state_nx = ST_WRC;
            ST_WRC:  if (mem_ack) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // memory request per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_RD:  begin mem_req = 1'b1; mem_addr = zaddr; end
            ST_WRZ: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = zaddr; mem_wdata = f_z; end
            ST_WRC: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = caddr; mem_wdata = f_c; end
            default: ;
        endcase
    end

    zt_perf #(.CW(CW)) i_perf (
        .clk(clk), .rst_n(rst_n),
        .inc_tested(state == ST_CMP),
        .inc_passed(state == ST_CMP && pass),
        .inc_busy(state != ST_IDLE),
        .cnt_tested(cnt_tested), .cnt_passed(cnt_passed), .cnt_busy(cnt_busy));

    // a pending request is not altered before its acknowledge
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // colour write follows the acknowledged depth write
    assert_colour_after_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRZ && mem_ack |=> mem_req && mem_we);

    // idle unit leaves the memory port quiet
    assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frag_ready |-> !mem_req);

    // never code discards the fragment
    assert_never_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CMP && f_fn == CMP_NEVER |=> !mem_req && frag_ready);

    // always code proceeds to a write
    assert_always_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CMP && f_fn == CMP_ALWAYS |=> mem_req && mem_we);

    // bypass starts with a write, not a read
    assert_bypass_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cfg_test_en |=> mem_req && mem_we);
endmodule

// File: tb/test_zt_depth_unit.sv
`timescale 1ns/1ps
module test_zt_depth_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frag_valid = 1'b0;
    logic        frag_ready;
    logic [10:0] frag_x = '0, frag_y = '0;
    logic [31:0] frag_z = '0, frag_rgba = '0;
    logic [2:0]  cfg_func = '0;
    logic        cfg_test_en = 1'b1;
    logic [31:0] cfg_zbase = 32'h0100_0000;
    logic [31:0] cfg_cbase = 32'h0200_0000;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] cnt_tested, cnt_passed, cnt_busy;

    int n_chk = 0, n_fail = 0;
    int exp_tested = 0, exp_passed = 0, exp_busy = 0;

    always #2 clk = ~clk;

    zt_depth_unit i_zt_depth_unit (.*);

    // memory model with access trace
    logic [31:0] mem [int unsigned];
    logic [31:0] tr_addr [16];
    logic        tr_we   [16];
    int          tr_n = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (tr_n < 16) begin
                tr_addr[tr_n] = mem_addr;
                tr_we[tr_n]   = mem_we;
            end
            tr_n = tr_n + 1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] paddr(input logic [31:0] base, input logic [10:0] x, input logic [10:0] y);
        return base + 32'(y) * 32'd2048 + 32'(x);
    endfunction

    typedef struct packed {
        logic [10:0] x;
        logic [10:0] y;
        logic [31:0] z;
        logic [31:0] old;
        logic [31:0] rgba;
        logic [2:0]  fn;
        logic        en;
        logic        pass;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{11'd0,    11'd0,    32'd5,          32'd10,         32'hA000_0001, 3'd1, 1'b1, 1'b1},
        '{11'd3,    11'd1,    32'd10,         32'd10,         32'hA000_0002, 3'd1, 1'b1, 1'b0},
        '{11'd6,    11'd2,    32'd7,          32'd7,          32'hA000_0003, 3'd2, 1'b1, 1'b1},
        '{11'd9,    11'd3,    32'd7,          32'd8,          32'hA000_0004, 3'd2, 1'b1, 1'b0},
        '{11'd12,   11'd4,    32'd9,          32'd9,          32'hA000_0005, 3'd3, 1'b1, 1'b1},
        '{11'd15,   11'd5,    32'd10,         32'd9,          32'hA000_0006, 3'd4, 1'b1, 1'b1},
        '{11'd18,   11'd6,    32'd9,          32'd9,          32'hA000_0007, 3'd4, 1'b1, 1'b0},
        '{11'd21,   11'd7,    32'd3,          32'd4,          32'hA000_0008, 3'd5, 1'b1, 1'b1},
        '{11'd24,   11'd8,    32'd0,          32'd1,          32'hA000_0009, 3'd6, 1'b1, 1'b0},
        '{11'd27,   11'd9,    32'd0,          32'hFFFF_FFFF,  32'hA000_000A, 3'd0, 1'b1, 1'b0},
        '{11'd30,   11'd10,   32'hFFFF_FFFF,  32'd0,          32'hA000_000B, 3'd7, 1'b1, 1'b1},
        '{11'd33,   11'd11,   32'h7FFF_FFFF,  32'h8000_0000,  32'hA000_000C, 3'd1, 1'b1, 1'b1},
        '{11'd36,   11'd12,   32'd50,         32'd1,          32'hA000_000D, 3'd1, 1'b0, 1'b1},
        '{11'd1279, 11'd1023, 32'd4,          32'd4,          32'hA000_000E, 3'd6, 1'b1, 1'b1}
    };

    // offer one fragment and wait until the unit is idle again
    task automatic run_frag(input vec_t v);
        @(negedge clk);
        cfg_func = v.fn; cfg_test_en = v.en;
        frag_x = v.x; frag_y = v.y; frag_z = v.z; frag_rgba = v.rgba;
        frag_valid = 1'b1;
        @(negedge clk);
        frag_valid = 1'b0;
        cfg_func = 3'd0; cfg_test_en = 1'b1;  // R9: later changes must not matter
        chk("R7 ready low after accept", 32'(frag_ready), 32'd0);
        while (!frag_ready) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 frag_ready", 32'(frag_ready), 32'd1);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 cnt_tested", cnt_tested, 32'd0);
        chk("R1 cnt_passed", cnt_passed, 32'd0);
        chk("R1 cnt_busy", cnt_busy, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            vec_t v = VEC[i];
            logic [31:0] za = paddr(cfg_zbase, v.x, v.y);
            logic [31:0] ca = paddr(cfg_cbase, v.x, v.y);
            mem[za] = v.old;
            mem[ca] = 32'hDEAD_BEEF;
            tr_n = 0;
            run_frag(v);
            if (!v.en) begin
                chk("R6 bypass access count", 32'(tr_n), 32'd1);
                chk("R6 bypass colour addr R2", tr_addr[0], ca);
                chk("R6 bypass is write", 32'(tr_we[0]), 32'd1);
                chk("R6 depth untouched", mem[za], v.old);
                chk("R6 colour written", mem[ca], v.rgba);
                exp_busy += 2;
            end else begin
                exp_tested++;
                chk("R3 first access reads depth R2", tr_addr[0], za);
                chk("R3 first access is read", 32'(tr_we[0]), 32'd0);
                if (v.pass) begin
                    exp_passed++;
                    exp_busy += 7;
                    chk("R4 pass access count", 32'(tr_n), 32'd3);
                    chk("R3 depth write second", {tr_addr[1][30:0], tr_we[1]}, {za[30:0], 1'b1});
                    chk("R3 colour write third R2", {tr_addr[2][30:0], tr_we[2]}, {ca[30:0], 1'b1});
                    chk("R4 new depth stored", mem[za], v.z);
                    chk("R4 colour stored", mem[ca], v.rgba);
                end else begin
                    exp_busy += 3;
                    chk("R5 fail access count", 32'(tr_n), 32'd1);
                    chk("R5 depth unchanged", mem[za], v.old);
                    chk("R5 colour unchanged", mem[ca], 32'hDEAD_BEEF);
                end
            end
        end
        chk("R8 cnt_tested", cnt_tested, 32'(exp_tested));
        chk("R8 cnt_passed", cnt_passed, 32'(exp_passed));
        chk("R8 cnt_busy", cnt_busy, 32'(exp_busy));

        // R7: two fragments offered back to back stay serial
        begin
            logic [31:0] za0 = paddr(cfg_zbase, 11'd100, 11'd50);
            logic [31:0] za1 = paddr(cfg_zbase, 11'd101, 11'd50);
            logic [31:0] ca0 = paddr(cfg_cbase, 11'd100, 11'd50);
            logic [31:0] ca1 = paddr(cfg_cbase, 11'd101, 11'd50);
            mem[za0] = 32'd100; mem[za1] = 32'd100;
            tr_n = 0;
            @(negedge clk);
            cfg_func = 3'd1; cfg_test_en = 1'b1;
            frag_x = 11'd100; frag_y = 11'd50; frag_z = 32'd1; frag_rgba = 32'hC0C0_0001;
            frag_valid = 1'b1;
            @(negedge clk);
            frag_x = 11'd101; frag_z = 32'd2; frag_rgba = 32'hC0C0_0002;
            while (!frag_ready) @(negedge clk);
            @(negedge clk);
            frag_valid = 1'b0;
            while (!frag_ready) @(negedge clk);
            chk("R7 serial access count", 32'(tr_n), 32'd6);
            chk("R7 first colour before second read", tr_addr[2], ca0);
            chk("R7 second fragment read", tr_addr[3], za1);
            chk("R7 second colour last", tr_addr[5], ca1);
            chk("R7 first depth", mem[za0], 32'd1);
            chk("R7 second depth", mem[za1], 32'd2);
            exp_tested += 2; exp_passed += 2; exp_busy += 14;
            chk("R8 final cnt_passed", cnt_passed, 32'(exp_passed));
            chk("R8 final cnt_busy", cnt_busy, 32'(exp_busy));
        end

        // R1: reset mid-stream clears counters
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 counters after reset", cnt_busy | cnt_tested | cnt_passed, 32'd0);
        chk("R1 ready after reset", 32'(frag_ready), 32'd1);
        finish_run();
    end
endmodule